// File: doc/BRIEF.md
# Hierarchical Domain Reset Controller

This block drives synchronous, active-low reset outputs for fourteen domains of a chip: eleven peripheral domains plus one each for GPIO, the watchdog and the CPU. Software writes to two control words. Each 1 in a control word starts a timed reset pulse, and reading a word back shows which pulses are still running. Most request bits target a single domain. Three wide requests cover nested groups of domains. A soft request resets all peripherals and GPIO. A peripheral request resets the peripherals only. A system request resets every domain.

Each request has its own down-counter. A request holds every domain it covers in reset for `PULSE_CYC` clock cycles, and then its bit clears itself. A domain is in reset while any counter that covers it is running. Writing a request again while it is running restarts its window. When a system pulse ends, the controller also drops every other request that was started earlier, so the chip comes out of a full reset with a clean request state.

Top module: `rst_ctrl`

## Requirements
- R1: While `rst_n` is low, every domain output is 0. At the first clock edge after release, every output is 1, and both control words read back as 0.
- R2: Word 0 (address `OFS0`, default 0x004) holds the single-domain request bits: DMA bit 0, watchdog bit 1, GPIO bit 2, timers 0/1/2 bits 5/6/7, UART0/UART1 bits 11/12, SPI0/SPI1 bits 13/14, I2C0 bit 16, RTC bit 17. Writing 1 to one of these bits drives the matching output low from the next clock edge for exactly `PULSE_CYC` cycles. Other outputs are not affected.
- R3: Word 1 (address `OFS1`, default 0x044), bit 0, requests the I2C1 domain and behaves like the bits in R2.
- R4: Writing 0 to a request bit has no effect. A write to any other address has no effect.
- R5: A request bit reads back as 1 while its pulse is running and as 0 once it has finished. Reads are combinational on `bus_addr`, and any other address reads back 0.
- R6: Word 0 bit 29 (soft) resets every peripheral domain and GPIO. It leaves the watchdog and CPU outputs high.
- R7: Word 0 bit 30 (peripheral) resets every peripheral domain. It leaves the GPIO, watchdog and CPU outputs high.
- R8: Word 0 bit 31 (system) resets all fourteen domains, the watchdog and CPU included.
- R9: Writing a request again while it is running restarts its window, so the output stays low for `PULSE_CYC` cycles counted from the latest write.
- R10: On the last cycle of a system pulse, every request started before that cycle is cancelled. A request written in that same cycle survives.
- R11: When requests overlap, each domain stays in reset for as long as any request that covers it is running.
- Output bit order for `dom_rst_n`: 0 DMA, 1 watchdog, 2 GPIO, 3–5 timers 0–2, 6 UART0, 7 UART1, 8 SPI0, 9 SPI1, 10 I2C0, 11 RTC, 12 I2C1, 13 CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| bus_wr_en | input | 1 | Write strobe for the control word at `bus_addr` |
| bus_addr | input | ADDR_W | Byte address of the control word (write and read) |
| bus_wdata | input | 32 | Write data; a 1 starts a request |
| bus_rdata | output | 32 | Busy image of the addressed control word |
| dom_rst_n | output | 14 | Active-low reset for each domain |

## Verification
Directed sequences write one group at a time: each single-domain bit, the I2C1 bit in the second word, soft, peripheral and system. This tells apart the three nested scopes by which of the GPIO, watchdog and CPU outputs stay high. Further directed cases cover a rewrite in the middle of a pulse, a zero write, a write to an unmapped address, and a system pulse that ends while other requests are still running. These separate a window that restarts from one that only runs out, and they show the cancellation at the end of a system pulse. Sparse random writes to both words and to unmapped addresses then build overlapping requests. On every cycle the bench compares all fourteen outputs and the readback against a cycle model, so any error in how the request windows are combined shows up.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_DOM = 14;
    localparam int NUM_REQ = 16;

    // domain indices (bit order of dom_rst_n)
    localparam int D_DMA   = 0;
    localparam int D_WDT   = 1;
    localparam int D_GPIO  = 2;
    localparam int D_TMR0  = 3;
    localparam int D_TMR1  = 4;
    localparam int D_TMR2  = 5;
    localparam int D_UART0 = 6;
    localparam int D_UART1 = 7;
    localparam int D_SPI0  = 8;
    localparam int D_SPI1  = 9;
    localparam int D_I2C0  = 10;
    localparam int D_RTC   = 11;
    localparam int D_I2C1  = 12;
    localparam int D_CPU   = 13;

    // request indices: 0..12 target the domain of the same index
    localparam int RQ_SOFT   = 13;
    localparam int RQ_PERIPH = 14;
    localparam int RQ_SYS    = 15;

    // bit positions the software view depends on
    localparam int POS_SOFT   = 29;
    localparam int POS_PERIPH = 30;
    localparam int POS_SYS    = 31;

    // domains that count as peripherals (not watchdog, GPIO, CPU)
    localparam logic [NUM_DOM-1:0] PERIPH_MASK =
        ~((NUM_DOM'(1) << D_WDT) | (NUM_DOM'(1) << D_GPIO) | (NUM_DOM'(1) << D_CPU));

    // which control word a request lives in
    function automatic int req_word(input int r);
        return (r == D_I2C1) ? 1 : 0;
    endfunction

    // bit position of a request inside its control word
    function automatic int req_pos(input int r);
        case (r)
            D_DMA:     return 0;
            D_WDT:     return 1;
            D_GPIO:    return 2;
            D_TMR0:    return 5;
            D_TMR1:    return 6;
            D_TMR2:    return 7;
            D_UART0:   return 11;
            D_UART1:   return 12;
            D_SPI0:    return 13;
            D_SPI1:    return 14;
            D_I2C0:    return 16;
            D_RTC:     return 17;
            D_I2C1:    return 0;
            RQ_SOFT:   return POS_SOFT;
            RQ_PERIPH: return POS_PERIPH;
            default:   return POS_SYS;
        endcase
    endfunction

    // set of domains a request holds in reset
    function automatic logic [NUM_DOM-1:0] req_cover(input int r);
        case (r)
            RQ_SOFT:   return PERIPH_MASK | (NUM_DOM'(1) << D_GPIO);
            RQ_PERIPH: return PERIPH_MASK;
            RQ_SYS:    return '1;
            default:   return NUM_DOM'(1) << r;
        endcase
    endfunction

endpackage

// File: rtl/rst_ctrl_regif.sv
module rst_ctrl_regif
    import rst_ctrl_pkg::*;
#(
    parameter int              ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFS0 = 12'h004,
    parameter logic [ADDR_W-1:0] OFS1 = 12'h044
) (
    input  logic                bus_wr_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [NUM_REQ-1:0]  busy,
    output logic [NUM_REQ-1:0]  start,
    output logic [DATA_W-1:0]   bus_rdata
);

    logic hit0, hit1;
    logic [DATA_W-1:0] img0, img1;

    assign hit0 = (bus_addr == OFS0);
    assign hit1 = (bus_addr == OFS1);

    // per-request start strobe: write of a 1 to its bit in its word
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_dec
        localparam int WORD = req_word(r);
        localparam int POS  = req_pos(r);
        if (WORD == 0) begin : g_w0
            assign start[r] = bus_wr_en && hit0 && bus_wdata[POS];
        end else begin : g_w1
            assign start[r] = bus_wr_en && hit1 && bus_wdata[POS];
        end
    end

    // busy images of both words
    always_comb begin
        img0 = '0;
        img1 = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (req_word(r) == 0) img0[req_pos(r)] = busy[r];
            else                  img1[req_pos(r)] = busy[r];
        end
    end

    always_comb begin
        if (hit0)      bus_rdata = img0;
        else if (hit1) bus_rdata = img1;
        else           bus_rdata = '0;
    end

endmodule

// File: rtl/rst_ctrl_req_timer.sv
module rst_ctrl_req_timer #(
    parameter int PULSE_CYC = 8,
    localparam int CNT_W    = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic flush,
    output logic busy,
    output logic busy_next,
    output logic last
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt = CNT_W'(PULSE_CYC);
        end else if (flush) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy      = (tmr_q.cnt != '0);
    assign busy_next = (tmr_d.cnt != '0);
    assign last      = (tmr_q.cnt == CNT_W'(1));

endmodule

// File: rtl/rst_ctrl_domain_map.sv
module rst_ctrl_domain_map
    import rst_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] busy_next,
    output logic [NUM_DOM-1:0] dom_rst_n
);

    typedef struct packed {
        logic [NUM_DOM-1:0] rst_n;
    } map_t;

    map_t map_d, map_q;
    logic [NUM_DOM-1:0] hold;

    // a domain is held while any covering request will be running
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic [NUM_REQ-1:0] src;
        for (genvar r = 0; r < NUM_REQ; r++) begin : g_src
            localparam logic [NUM_DOM-1:0] COV = req_cover(r);
            assign src[r] = COV[d] & busy_next[r];
        end
        assign hold[d] = |src;
    end

    always_comb begin
        map_d       = map_q;
        map_d.rst_n = ~hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    assign dom_rst_n = map_q.rst_n;

endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
    import rst_ctrl_pkg::*;
#(
    parameter int                PULSE_CYC = 8,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] OFS0      = 12'h004,
    parameter logic [ADDR_W-1:0] OFS1      = 12'h044
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_en,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_DOM-1:0]   dom_rst_n
);

    logic [NUM_REQ-1:0] start, busy, busy_next, last;
    logic               sys_done;

    rst_ctrl_regif #(
        .ADDR_W (ADDR_W),
        .OFS0   (OFS0),
        .OFS1   (OFS1)
    ) u_regif (
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .start     (start),
        .bus_rdata (bus_rdata)
    );

    // end of a system pulse cancels older requests
    assign sys_done = last[RQ_SYS];

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        rst_ctrl_req_timer #(
            .PULSE_CYC (PULSE_CYC)
        ) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start[r]),
            .flush     (sys_done),
            .busy      (busy[r]),
            .busy_next (busy_next[r]),
            .last      (last[r])
        );
    end

    rst_ctrl_domain_map u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_next (busy_next),
        .dom_rst_n (dom_rst_n)
    );

endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk
    import rst_ctrl_pkg::*;
#(
    parameter int                ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFS0   = 12'h004,
    parameter logic [ADDR_W-1:0] OFS1   = 12'h044
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr_en,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_DOM-1:0] dom_rst_n
);

    logic w0, w1;
    assign w0 = bus_wr_en && (bus_addr == OFS0);
    assign w1 = bus_wr_en && (bus_addr == OFS1);

    // R2
    dma_req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w0 && bus_wdata[0]) |=> !dom_rst_n[D_DMA]);

    // R3
    i2c1_req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1 && bus_wdata[0]) |=> !dom_rst_n[D_I2C1]);

    // R8
    sys_req_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w0 && bus_wdata[POS_SYS]) |=> (dom_rst_n == '0));

    // R6
    cpu_only_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_rst_n[D_CPU]) |-> $past(w0 && bus_wdata[POS_SYS]));

    // R7
    wdt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_rst_n[D_WDT]) |-> $past(w0 && (bus_wdata[1] || bus_wdata[POS_SYS])));

    // R5
    busy_matches_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == OFS0) && bus_rdata[0]) |-> !dom_rst_n[D_DMA]);

endmodule

bind rst_ctrl rst_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .OFS0   (OFS0),
    .OFS1   (OFS1)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dom_rst_n (dom_rst_n)
);

// File: tb/rst_ctrl_tb.sv
`timescale 1ns/1ps
module rst_ctrl_tb;

    localparam int PULSE = 8;
    localparam int NREQ  = 16;
    localparam int NDOM  = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [13:0] dom_rst_n;

    int vec_cnt = 0;
    int err_cnt = 0;
    int cnt[NREQ];

    always #2 clk = ~clk;

    rst_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dom_rst_n (dom_rst_n)
    );

    // bench view of the software map: word, bit, covered domains
    function automatic int bit_of(input int r);
        int tbl[NREQ] = '{0, 1, 2, 5, 6, 7, 11, 12, 13, 14, 16, 17, 0, 29, 30, 31};
        return tbl[r];
    endfunction

    function automatic logic [11:0] addr_of(input int r);
        return (r == 12) ? 12'h044 : 12'h004;
    endfunction

    function automatic logic [13:0] cover_of(input int r);
        logic [13:0] periph = 14'b01_1111_1111_1001;
        if (r == 13) return periph | 14'h0004;
        if (r == 14) return periph;
        if (r == 15) return 14'h3FFF;
        return 14'd1 << r;
    endfunction

    function automatic logic [13:0] exp_dom();
        logic [13:0] held = '0;
        for (int r = 0; r < NREQ; r++)
            if (cnt[r] > 0) held |= cover_of(r);
        return ~held;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        logic [31:0] v = '0;
        for (int r = 0; r < NREQ; r++)
            if (addr_of(r) == a && cnt[r] > 0) v[bit_of(r)] = 1'b1;
        return v;
    endfunction

    task automatic model_edge(input logic we, input logic [11:0] a, input logic [31:0] d);
        bit sys_last = (cnt[15] == 1);
        for (int r = 0; r < NREQ; r++) begin
            if (we && a == addr_of(r) && d[bit_of(r)]) cnt[r] = PULSE;
            else if (sys_last)                          cnt[r] = 0;
            else if (cnt[r] > 0)                        cnt[r] = cnt[r] - 1;
        end
    endtask

    task automatic check(input string tag);
        logic [13:0] ed = exp_dom();
        logic [31:0] er = exp_rd(bus_addr);
        vec_cnt++;
        if (dom_rst_n !== ed) begin
            err_cnt++;
            $display("FAIL %s dom_rst_n actual=%h expected=%h", tag, dom_rst_n, ed);
        end
        vec_cnt++;
        if (bus_rdata !== er) begin
            err_cnt++;
            $display("FAIL %s bus_rdata actual=%h expected=%h", tag, bus_rdata, er);
        end
    endtask

    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_wr_en = we;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        model_edge(we, a, d);
        #1;
        check(tag);
    endtask

    task automatic idle(input int n, input logic [11:0] a, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, a, 32'h0, tag);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    endtask

    initial begin
        #400000;
        err_cnt++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int low_cnt;
        void'($urandom(32'd20240611));
        for (int r = 0; r < NREQ; r++) cnt[r] = 0;

        // R1: held low during reset, released after first edge
        #1;
        vec_cnt++;
        if (dom_rst_n !== 14'h0) begin
            err_cnt++;
            $display("FAIL R1 dom_rst_n in reset actual=%h expected=0000", dom_rst_n);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2, 12'h004, "R1");
        idle(1, 12'h044, "R1");

        // R2: each single-domain bit of word 0, exact pulse width
        for (int r = 0; r < 12; r++) begin
            step(1'b1, 12'h004, 32'd1 << bit_of(r), "R2");
            idle(PULSE + 1, 12'h004, "R2");
        end
        // R2 width measured directly on the DMA output
        step(1'b1, 12'h004, 32'h1, "R2");
        low_cnt = 1;
        for (int i = 0; i < PULSE + 2; i++) begin
            step(1'b0, 12'h004, 32'h0, "R2");
            if (!dom_rst_n[0]) low_cnt++;
        end
        vec_cnt++;
        if (low_cnt != PULSE) begin
            err_cnt++;
            $display("FAIL R2 DMA low cycles actual=%0d expected=%0d", low_cnt, PULSE);
        end

        // R3: I2C1 in word 1
        step(1'b1, 12'h044, 32'h1, "R3");
        idle(PULSE + 1, 12'h044, "R3");

        // R4: zero write, unmapped address
        step(1'b1, 12'h004, 32'h0, "R4");
        step(1'b1, 12'h008, 32'hFFFF_FFFF, "R4");
        step(1'b1, 12'h000, 32'hFFFF_FFFF, "R4");
        idle(1, 12'h008, "R4");

        // R5: readback busy then done
        step(1'b1, 12'h004, 32'h0002_0000, "R5");
        idle(PULSE + 1, 12'h004, "R5");

        // R6 soft, R7 peripheral, R8 system
        step(1'b1, 12'h004, 32'h2000_0000, "R6");
        idle(PULSE + 1, 12'h004, "R6");
        step(1'b1, 12'h004, 32'h4000_0000, "R7");
        idle(PULSE + 1, 12'h004, "R7");
        step(1'b1, 12'h004, 32'h8000_0000, "R8");
        idle(PULSE + 1, 12'h004, "R8");

        // R9: rewrite mid-pulse restarts window
        step(1'b1, 12'h004, 32'h0000_0020, "R9");
        idle(4, 12'h004, "R9");
        step(1'b1, 12'h004, 32'h0000_0020, "R9");
        idle(PULSE + 1, 12'h004, "R9");

        // R10: system end cancels older requests, same-cycle write survives
        step(1'b1, 12'h004, 32'h8000_0000, "R10");
        idle(2, 12'h004, "R10");
        step(1'b1, 12'h004, 32'h0000_0801, "R10");
        step(1'b1, 12'h044, 32'h1, "R10");
        idle(PULSE - 5, 12'h004, "R10");
        step(1'b1, 12'h004, 32'h0000_0004, "R10");
        idle(PULSE + 1, 12'h004, "R10");

        // R11: overlapping soft and single GPIO
        step(1'b1, 12'h004, 32'h2000_0000, "R11");
        idle(5, 12'h004, "R11");
        step(1'b1, 12'h004, 32'h0000_0004, "R11");
        idle(PULSE + 1, 12'h004, "R11");

        // R11: sparse random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] d = $urandom & $urandom & $urandom;
            logic [11:0] a;
            case ($urandom % 4)
                0, 1:    a = 12'h004;
                2:       a = 12'h044;
                default: a = 12'h008;
            endcase
            if (($urandom % 8) != 0) d[31] = 1'b0;
            step(($urandom % 3) == 0, a, d, "R11");
        end

        finish_run();
    end

endmodule